// File: doc/BRIEF.md
# Serial Port Event Request Logic

This block keeps the six status flags of an asynchronous serial port and turns them into four level-type interrupt request lines and two transfer-trigger lines for a DMA engine. The four interrupt lines are transmit buffer empty, receive buffer full, receive error and transmit complete. The transmitter and receiver cores report events as one-cycle set pulses. Enable bits from the control register decide which flags reach the interrupt controller.

A DMA engine moving bytes in or out of the port clears the matching data flag as a side effect of its data-register access. No software step is needed for that. The CPU clears the error and transmit-complete flags with a read-then-write-zero sequence.

An error-only mode keeps correctly received bytes off the CPU interrupt line while still triggering the DMA engine. With this mode, the CPU is only disturbed when a receive error occurs.

Top module: `ser_irq_req`

## Requirements
- R1: Reset state. After reset, `sts_flags` reads 6'b100001 and all six request outputs are 0. The flag bits are:
  - bit 0: transmit empty
  - bit 1: receive full
  - bit 2: overrun
  - bit 3: framing error
  - bit 4: parity error
  - bit 5: transmit complete
- R2: Transmit-empty interrupt. `irq_txe` is 1 in the cycle after transmit-empty flag (bit 0) and `en_txe` are both 1. It returns to 0 in the cycle after either of them is 0.
- R3: Receive-full interrupt. `irq_rxf` is 1 in the cycle after receive-full flag (bit 1) and `en_rx` are both 1 and `err_only` is 0. It is 0 in the cycle after any of those conditions fails.
- R4: Receive-error interrupt. `irq_err` is 1 in the cycle after any of bits 2, 3 or 4 is 1 while `en_rx` is 1, whatever the value of `err_only`. It is 0 otherwise.
- R5: Transmit-complete interrupt. `irq_tdn` is 1 in the cycle after bit 5 and `en_tdn` are both 1, and 0 otherwise.
- R6: DMA triggers. `dreq_tx` follows bit 0 gated by `en_txe`. `dreq_rx` follows bit 1 gated by `en_rx` and is not suppressed by `err_only`. Both take one cycle of latency. The error flags and the transmit-complete flag never drive a DMA trigger.
- R7: DMA-side clears. A `dma_tx_wr` pulse clears bit 0 at the next edge, and a `dma_rx_rd` pulse clears bit 1 at the next edge.
- R8: Set wins over clear. A set pulse in the same cycle as any clear of the same flag leaves that flag at 1.
- R9: CPU clear sequence. Bits 2 to 5 are cleared by a `cpu_sts_wr` whose data bit is 0, but only if a `cpu_sts_rd` saw that flag at 1 in an earlier cycle. Without that earlier read, a write of 0 leaves the flag unchanged.
- R10: Writes that have no effect. A CPU write of 1 to any flag has no effect. CPU writes never change bits 0 and 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| set_txe | input | 1 | Pulse that sets transmit-empty flag |
| set_rxf | input | 1 | Pulse that sets receive-full flag |
| set_ovr | input | 1 | Pulse that sets overrun flag |
| set_frm | input | 1 | Pulse that sets framing-error flag |
| set_par | input | 1 | Pulse that sets parity-error flag |
| set_tdn | input | 1 | Pulse that sets transmit-complete flag |
| en_txe | input | 1 | Transmit-empty interrupt enable |
| en_rx | input | 1 | Enable shared by the receive-full and error interrupts |
| en_tdn | input | 1 | Transmit-complete interrupt enable |
| err_only | input | 1 | Error-only mode: keeps receive-full off the CPU line |
| cpu_sts_rd | input | 1 | CPU read strobe of the status register |
| cpu_sts_wr | input | 1 | CPU write strobe of the status register |
| cpu_sts_wdata | input | 6 | CPU write data, in the same bit layout as `sts_flags` |
| dma_tx_wr | input | 1 | DMA write of the transmit data register |
| dma_rx_rd | input | 1 | DMA read of the receive data register |
| sts_flags | output | 6 | Current flag values |
| irq_txe | output | 1 | Transmit-empty interrupt request |
| irq_rxf | output | 1 | Receive-full interrupt request |
| irq_err | output | 1 | Receive-error interrupt request |
| irq_tdn | output | 1 | Transmit-complete interrupt request |
| dreq_tx | output | 1 | DMA trigger for transmit |
| dreq_rx | output | 1 | DMA trigger for receive |

## Verification
Directed sequences toggle each enable with its flag held, so that a missing or swapped gate term shows up on the matching output alone. Error-only mode is run with a received byte pending, to separate the CPU receive-full line from the receive DMA trigger. Set pulses that coincide with DMA clears check the set-wins priority. CPU write-zero attempts with and without a prior read, together with write-one attempts, separate a correct arming rule from one that clears too eagerly. A run of pseudo-random stimulus then mixes every input against a cycle-level model held in the bench.

// File: rtl/ser_irq_pkg.sv
package ser_irq_pkg;
  localparam int NFLAG = 6;
  localparam int F_TXE = 0;
  localparam int F_RXF = 1;
  localparam int F_OVR = 2;
  localparam int F_FRM = 3;
  localparam int F_PAR = 4;
  localparam int F_TDN = 5;

  // Reset value per flag: transmit side starts idle and empty.
  localparam logic [NFLAG-1:0] FLAG_RST     = 6'b100001;
  // Flags the CPU may clear with the read-then-write-zero sequence.
  localparam logic [NFLAG-1:0] CPU_CLR_MASK = 6'b111100;

  typedef struct packed {
    logic txe;
    logic rxf;
    logic err;
    logic tdn;
    logic dtx;
    logic drx;
  } req_t;
endpackage

// File: rtl/ser_rst_sync.sv
module ser_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n
);
  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  always_comb begin
    sh_d = {sh_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sh_q <= '0;
    else         sh_q <= sh_d;
  end

  assign rst_n = sh_q[STAGES-1];
endmodule

// File: rtl/ser_flag_cell.sv
module ser_flag_cell #(
  parameter logic RST_VAL = 1'b0,
  parameter logic CPU_CLR = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic set_p,
  input  logic hw_clr,
  input  logic cpu_rd,
  input  logic cpu_wr,
  input  logic cpu_wbit,
  output logic flag
);
  logic flag_q, flag_d, flag_en;
  logic arm_q, arm_d;
  logic sw_clr;

  always_comb begin
    sw_clr  = CPU_CLR & arm_q & cpu_wr & ~cpu_wbit;
    flag_en = set_p | hw_clr | sw_clr;
    if (set_p)                flag_d = 1'b1;
    else if (hw_clr | sw_clr) flag_d = 1'b0;
    else                      flag_d = flag_q;
    // Arm when the CPU reads the flag as 1; disarm on any clear attempt.
    if (!flag_d || sw_clr)      arm_d = 1'b0;
    else if (cpu_rd && flag_q)  arm_d = 1'b1;
    else                        arm_d = arm_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= RST_VAL;
    end else if (flag_en) begin
      flag_q <= flag_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) arm_q <= 1'b0;
    else        arm_q <= arm_d;
  end

  assign flag = flag_q;
endmodule

// File: rtl/ser_req_map.sv
module ser_req_map
  import ser_irq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NFLAG-1:0] flags,
  input  logic             en_txe,
  input  logic             en_rx,
  input  logic             en_tdn,
  input  logic             err_only,
  output req_t             req_q
);
  req_t req_d;
  logic any_err;

  always_comb begin
    any_err   = flags[F_OVR] | flags[F_FRM] | flags[F_PAR];
    req_d.txe = flags[F_TXE] & en_txe;
    req_d.rxf = flags[F_RXF] & en_rx & ~err_only;
    req_d.err = any_err & en_rx;
    req_d.tdn = flags[F_TDN] & en_tdn;
    req_d.dtx = flags[F_TXE] & en_txe;
    req_d.drx = flags[F_RXF] & en_rx;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) req_q <= '0;
    else        req_q <= req_d;
  end
endmodule

// File: rtl/ser_irq_req.sv
module ser_irq_req
  import ser_irq_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             set_txe,
  input  logic             set_rxf,
  input  logic             set_ovr,
  input  logic             set_frm,
  input  logic             set_par,
  input  logic             set_tdn,
  input  logic             en_txe,
  input  logic             en_rx,
  input  logic             en_tdn,
  input  logic             err_only,
  input  logic             cpu_sts_rd,
  input  logic             cpu_sts_wr,
  input  logic [NFLAG-1:0] cpu_sts_wdata,
  input  logic             dma_tx_wr,
  input  logic             dma_rx_rd,
  output logic [NFLAG-1:0] sts_flags,
  output logic             irq_txe,
  output logic             irq_rxf,
  output logic             irq_err,
  output logic             irq_tdn,
  output logic             dreq_tx,
  output logic             dreq_rx
);
  logic             rst_sync_n;
  logic [NFLAG-1:0] set_vec;
  logic [NFLAG-1:0] hw_clr_vec;
  logic [NFLAG-1:0] flag_vec;
  req_t             req;

  ser_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .rst_n  (rst_sync_n)
  );

  always_comb begin
    set_vec           = '0;
    set_vec[F_TXE]    = set_txe;
    set_vec[F_RXF]    = set_rxf;
    set_vec[F_OVR]    = set_ovr;
    set_vec[F_FRM]    = set_frm;
    set_vec[F_PAR]    = set_par;
    set_vec[F_TDN]    = set_tdn;
    hw_clr_vec        = '0;
    hw_clr_vec[F_TXE] = dma_tx_wr;
    hw_clr_vec[F_RXF] = dma_rx_rd;
  end

  for (genvar g = 0; g < NFLAG; g++) begin : g_flag
    ser_flag_cell #(
      .RST_VAL (FLAG_RST[g]),
      .CPU_CLR (CPU_CLR_MASK[g])
    ) u_cell (
      .clk      (clk),
      .rst_n    (rst_sync_n),
      .set_p    (set_vec[g]),
      .hw_clr   (hw_clr_vec[g]),
      .cpu_rd   (cpu_sts_rd),
      .cpu_wr   (cpu_sts_wr),
      .cpu_wbit (cpu_sts_wdata[g]),
      .flag     (flag_vec[g])
    );
  end

  ser_req_map u_map (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .flags    (flag_vec),
    .en_txe   (en_txe),
    .en_rx    (en_rx),
    .en_tdn   (en_tdn),
    .err_only (err_only),
    .req_q    (req)
  );

  assign sts_flags = flag_vec;
  assign irq_txe   = req.txe;
  assign irq_rxf   = req.rxf;
  assign irq_err   = req.err;
  assign irq_tdn   = req.tdn;
  assign dreq_tx   = req.dtx;
  assign dreq_rx   = req.drx;
endmodule

// File: rtl/ser_irq_req_chk.sv
module ser_irq_req_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [5:0] sts_flags,
  input logic       en_txe,
  input logic       en_rx,
  input logic       en_tdn,
  input logic       err_only,
  input logic       set_txe,
  input logic       set_rxf,
  input logic       dma_tx_wr,
  input logic       dma_rx_rd,
  input logic       cpu_sts_wr,
  input logic       cpu_wbit2,
  input logic       irq_txe,
  input logic       irq_rxf,
  input logic       irq_err,
  input logic       irq_tdn,
  input logic       dreq_rx
);
  AST_TXE_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_flags[0] && en_txe) |=> irq_txe); // R2
  AST_TXE_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    !(sts_flags[0] && en_txe) |=> !irq_txe); // R2
  AST_RXF_MUTED: assert property (@(posedge clk) disable iff (!rst_n)
    err_only |=> !irq_rxf); // R3
  AST_ERR_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
    (en_rx && (sts_flags[2] || sts_flags[3] || sts_flags[4])) |=> irq_err); // R4
  AST_TDN_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_flags[5] && en_tdn) |=> irq_tdn); // R5
  AST_DRX_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_flags[1] && en_rx) |=> dreq_rx); // R6
  AST_DMA_TX_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_tx_wr && !set_txe) |=> !sts_flags[0]); // R7
  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (set_rxf && dma_rx_rd) |=> sts_flags[1]); // R8
  AST_W1_NOP: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_sts_wr && cpu_wbit2 && sts_flags[2]) |=> sts_flags[2]); // R10
  AST_DATA_NO_CPU: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_sts_wr && sts_flags[1] && !dma_rx_rd) |=> sts_flags[1]); // R10
endmodule

bind ser_irq_req ser_irq_req_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_sync_n),
  .sts_flags  (sts_flags),
  .en_txe     (en_txe),
  .en_rx      (en_rx),
  .en_tdn     (en_tdn),
  .err_only   (err_only),
  .set_txe    (set_txe),
  .set_rxf    (set_rxf),
  .dma_tx_wr  (dma_tx_wr),
  .dma_rx_rd  (dma_rx_rd),
  .cpu_sts_wr (cpu_sts_wr),
  .cpu_wbit2  (cpu_sts_wdata[2]),
  .irq_txe    (irq_txe),
  .irq_rxf    (irq_rxf),
  .irq_err    (irq_err),
  .irq_tdn    (irq_tdn),
  .dreq_rx    (dreq_rx)
);

// File: tb/ser_irq_req_tb.sv
module ser_irq_req_tb;
  logic clk = 1'b0;
  logic rst_n;
  logic set_txe, set_rxf, set_ovr, set_frm, set_par, set_tdn;
  logic en_txe, en_rx, en_tdn, err_only;
  logic cpu_sts_rd, cpu_sts_wr;
  logic [5:0] cpu_sts_wdata;
  logic dma_tx_wr, dma_rx_rd;
  logic [5:0] sts_flags;
  logic irq_txe, irq_rxf, irq_err, irq_tdn, dreq_tx, dreq_rx;

  always #4 clk = ~clk; // 125 MHz

  ser_irq_req u_dut (.*);

  typedef struct {
    logic [5:0] sts;
    logic [5:0] outs;
    string      tag;
  } exp_t;

  exp_t q[$];
  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  // bench model state
  logic [5:0] m_f;
  logic [5:0] m_arm;

  task automatic clear_pulses();
    {set_txe, set_rxf, set_ovr, set_frm, set_par, set_tdn} = '0;
    {cpu_sts_rd, cpu_sts_wr, dma_tx_wr, dma_rx_rd} = '0;
    cpu_sts_wdata = '0;
  endtask

  // Driver: compute the expected post-edge state from the requirements, push it, advance.
  task automatic cyc(input string tag);
    exp_t e;
    logic [5:0] setv, nf, na;
    setv = {set_tdn, set_par, set_frm, set_ovr, set_rxf, set_txe};
    e.outs = {m_f[0] & en_txe, m_f[1] & en_rx & ~err_only,
              (m_f[2] | m_f[3] | m_f[4]) & en_rx, m_f[5] & en_tdn,
              m_f[0] & en_txe, m_f[1] & en_rx};
    for (int i = 0; i < 6; i++) begin
      logic hw, sw;
      hw = (i == 0 && dma_tx_wr) || (i == 1 && dma_rx_rd);
      sw = (i >= 2) && m_arm[i] && cpu_sts_wr && !cpu_sts_wdata[i];
      nf[i] = setv[i] ? 1'b1 : ((hw || sw) ? 1'b0 : m_f[i]);
      na[i] = (!nf[i] || sw) ? 1'b0 : ((cpu_sts_rd && m_f[i]) ? 1'b1 : m_arm[i]);
    end
    m_f = nf;
    m_arm = na;
    e.sts = nf;
    e.tag = tag;
    q.push_back(e);
    @(negedge clk);
    clear_pulses();
  endtask

  // Monitor: sample after each edge and compare against the oldest expectation.
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (q.size() > 0) begin
        exp_t e;
        logic [5:0] act;
        e = q.pop_front();
        act = {irq_txe, irq_rxf, irq_err, irq_tdn, dreq_tx, dreq_rx};
        n_chk++;
        if (act !== e.outs || sts_flags !== e.sts) begin
          n_fail++;
          $display("FAIL %s sts=%b outs=%b expected sts=%b outs=%b",
                   e.tag, sts_flags, act, e.sts, e.outs);
        end
      end
    end
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    clear_pulses();
    {en_txe, en_rx, en_tdn, err_only} = '0;
    m_f = 6'b100001;
    m_arm = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    n_chk++;
    if (sts_flags !== 6'b100001 ||
        {irq_txe, irq_rxf, irq_err, irq_tdn, dreq_tx, dreq_rx} !== 6'b0) begin
      n_fail++;
      $display("FAIL R1 sts=%b outs=%b expected sts=100001 outs=000000", sts_flags,
               {irq_txe, irq_rxf, irq_err, irq_tdn, dreq_tx, dreq_rx});
    end
    cyc("R1");

    // R2 transmit-empty gating
    en_txe = 1; cyc("R2"); cyc("R2");
    en_txe = 0; cyc("R2"); cyc("R2");
    en_txe = 1; cyc("R2");

    // R7 DMA write clears transmit-empty, R8 set wins
    dma_tx_wr = 1; cyc("R7"); cyc("R7");
    set_txe = 1; cyc("R2"); cyc("R2");
    set_txe = 1; dma_tx_wr = 1; cyc("R8"); cyc("R8");

    // R3 / R6 receive-full with and without error-only mode
    en_rx = 1; set_rxf = 1; cyc("R3"); cyc("R3"); cyc("R3");
    err_only = 1; cyc("R3"); cyc("R6"); cyc("R6");
    dma_rx_rd = 1; cyc("R7"); cyc("R7");
    set_rxf = 1; dma_rx_rd = 1; cyc("R8"); cyc("R8");
    err_only = 0; cyc("R3"); cyc("R3");

    // R4 error raises CPU line in error-only mode
    err_only = 1; set_ovr = 1; cyc("R4"); cyc("R4"); cyc("R4");
    en_rx = 0; cyc("R4"); cyc("R4");
    en_rx = 1;

    // R9 write zero without prior read leaves flags
    cpu_sts_wr = 1; cpu_sts_wdata = 6'b000000; cyc("R9"); cyc("R9");
    cpu_sts_rd = 1; cyc("R9");
    // R10 write of ones keeps armed flags
    cpu_sts_wr = 1; cpu_sts_wdata = 6'b111111; cyc("R10"); cyc("R10");
    cpu_sts_rd = 1; cyc("R9");
    cpu_sts_wr = 1; cpu_sts_wdata = 6'b000000; cyc("R9"); cyc("R10"); cyc("R9");

    // R5 transmit complete
    en_tdn = 1; set_tdn = 1; cyc("R5"); cyc("R5");
    en_tdn = 0; cyc("R5"); cyc("R5");

    // framing and parity with the shared enable
    set_frm = 1; set_par = 1; cyc("R4"); cyc("R4");
    cpu_sts_rd = 1; set_frm = 1; cyc("R9");
    cpu_sts_wr = 1; cpu_sts_wdata = 6'b101000; cyc("R9"); cyc("R4");

    // mixed pseudo-random traffic
    for (int k = 0; k < 400; k++) begin
      logic [31:0] r;
      r = $urandom;
      {set_txe, set_rxf, set_ovr, set_frm, set_par, set_tdn} = r[5:0] & r[11:6];
      {en_txe, en_rx, en_tdn, err_only} = r[15:12];
      cpu_sts_rd = r[16] & r[17];
      cpu_sts_wr = r[18] & r[19];
      cpu_sts_wdata = r[25:20];
      dma_tx_wr = r[26] & r[27];
      dma_rx_rd = r[28] & r[29];
      cyc("R6");
    end

    @(negedge clk);
    @(negedge clk);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule